// File: doc/BRIEF.md
# Conditional Operation Stack

This block is an ordered holding queue that sits between an instruction issuer and one execution unit. The issuer pushes operations in program order. While a branch outcome is still unknown, it marks each pushed operation as conditional. The queue retires entries strictly one at a time from its head. A conditional entry at the head is held until the issuer resolves the pending branch.

The issuer resolves the branch with a single strobe. An activate strobe turns every conditional entry into a normal one. A cancel strobe condemns every conditional entry, and each condemned entry is then discarded at the head in one cycle without reaching the execution unit. Only one branch level may be pending at a time.

Each entry also carries a latency class. The class sets how long after decode the entry's position is handed back to the issuer. A full flag tells the issuer to stop pushing. Occupancy counts both stored entries and decoded entries whose position has not yet been returned.

Top module: `cond_op_stack`

## Requirements
- R1: After reset the stack is empty: `full`, `dec_valid` and `drop` are low and `free_cnt` is 0.
- R2: Entries leave the head in push order, at most one per cycle. `dec_valid` and `drop` are never high in the same cycle.
- R3: A normal entry at the head is decoded in any cycle in which `exec_ready` is high. It stays at the head, with `dec_valid` low, while `exec_ready` is low. An entry pushed in cycle c can be decoded at the earliest in cycle c+1.
- R4: A conditional entry is never decoded. `br_activate` and `br_cancel` are registered for one cycle before they act. If a strobe is high in cycle t and a conditional entry is at the head with `exec_ready` high, that entry stays undecoded in cycles t and t+1 and is decoded (after activate) or dropped (after cancel) in cycle t+2.
- R5: After `br_cancel`, every entry that was conditional is consumed at the head with `drop` high for exactly one cycle, whatever the state of `exec_ready`. It never raises `dec_valid`.
- R6: A resolution acts on every conditional entry held in the stack. It also acts on a conditional entry pushed in the cycle after the strobe. Normal entries queued behind condemned ones are still decoded.
- R7: The latency class is encoded on `push_lat` and `out_lat` as 0 = one cycle, 1 = two cycles, and 2 or 3 = three or more cycles. The position of a class 0 entry is returned in its decode cycle, a class 1 entry one cycle later, and a class 2 or 3 entry two cycles later. A dropped entry's position is returned in its drop cycle.
- R8: `full` is high exactly when the number of stored entries plus decoded entries awaiting return equals DEPTH. A push while `full` is high is ignored.
- R9: `free_cnt` reports how many positions are returned in the cycle, up to 3 when returns from several entries coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Push an operation this cycle |
| push_op | input | OPW | Operation code pushed |
| push_cond | input | 1 | Pushed operation depends on the pending branch |
| push_lat | input | 2 | Latency class of the pushed operation (R7 encoding) |
| full | output | 1 | No position available; the issuer must stall |
| br_activate | input | 1 | Pending branch falls through; conditional entries become normal |
| br_cancel | input | 1 | Pending branch is taken; conditional entries are condemned |
| exec_ready | input | 1 | Operands ready and execution hardware idle |
| dec_valid | output | 1 | Head entry decoded; execution starts next cycle |
| drop | output | 1 | Head entry discarded as condemned |
| out_op | output | OPW | Operation code of the head entry, valid with `dec_valid` or `drop` |
| out_lat | output | 2 | Latency class of the head entry, valid with `dec_valid` or `drop` |
| free_cnt | output | 2 | Number of positions returned to the issuer this cycle |

## Verification
The assertions assume that the issuer never raises `br_activate` and `br_cancel` together, and that a new conditional operation enters only after the previous resolution. That is, it enters in the cycle after the strobe or later. The stimulus keeps to this by sending each resolution as a single one-cycle strobe. It follows a strobe either with an idle cycle or with a conditional push that the bench itself expects to be resolved. Pushes made while `full` is high are driven on purpose, and the scoreboard leaves them out of its expected stream.

// File: rtl/cos_pkg.sv
package cos_pkg;

   typedef enum logic [1:0] {
      LAT_ONE    = 2'd0,
      LAT_TWO    = 2'd1,
      LAT_LONG   = 2'd2,
      LAT_LONGER = 2'd3
   } lat_class_e;

   typedef enum logic [1:0] {
      HD_EMPTY = 2'd0,
      HD_WAIT  = 2'd1,
      HD_KILL  = 2'd2,
      HD_LIVE  = 2'd3
   } head_state_e;

   localparam int MAX_FREE_DLY = 2;

   function automatic int free_delay(input logic [1:0] lat, input int long_dly);
      case (lat_class_e'(lat))
         LAT_ONE: return 0;
         LAT_TWO: return 1;
         default: return long_dly;
      endcase
   endfunction

endpackage

// File: rtl/cos_ring.sv
module cos_ring #(
   parameter int DEPTH = 8,
   parameter int OPW   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [OPW-1:0]    wr_op,
   input  logic              wr_cond,
   input  logic [1:0]        wr_lat,
   input  logic              rd_en,
   input  logic              act_q,
   input  logic              can_q,
   output logic              head_vld,
   output logic [OPW-1:0]    head_op,
   output logic [1:0]        head_lat,
   output logic              head_cond,
   output logic              head_kill,
   output logic [$clog2(DEPTH+1)-1:0] count
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   logic [OPW-1:0]   op_mem  [DEPTH];
   logic [1:0]       lat_mem [DEPTH];
   logic [DEPTH-1:0] cond_r;
   logic [DEPTH-1:0] kill_r;
   logic [PW-1:0]    wr_ptr, rd_ptr;
   logic [CW-1:0]    cnt;

   function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (wr_en) wr_ptr <= bump(wr_ptr);
         if (rd_en) rd_ptr <= bump(rd_ptr);
         cnt <= cnt + CW'(wr_en) - CW'(rd_en);
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         op_mem[wr_ptr]  <= wr_op;
         lat_mem[wr_ptr] <= wr_lat;
      end
   end

   // per-slot tag state: a write takes the resolution landing in the same cycle
   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cond_r[i] <= 1'b0;
            kill_r[i] <= 1'b0;
         end else if (wr_en && (wr_ptr == PW'(i))) begin
            cond_r[i] <= wr_cond && !act_q && !can_q;
            kill_r[i] <= wr_cond && can_q;
         end else if (act_q) begin
            cond_r[i] <= 1'b0;
         end else if (can_q) begin
            kill_r[i] <= kill_r[i] | cond_r[i];
            cond_r[i] <= 1'b0;
         end
      end
   end

   assign count     = cnt;
   assign head_vld  = (cnt != '0);
   assign head_op   = op_mem[rd_ptr];
   assign head_lat  = lat_mem[rd_ptr];
   assign head_cond = cond_r[rd_ptr];
   assign head_kill = kill_r[rd_ptr];

   // R6: a landed resolution leaves no conditional tag anywhere
   a_r6_resolve_clears_tags: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q || can_q) |=> (cond_r == '0));

   // R8: writes never land in a full ring
   a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (cnt < CW'(DEPTH)));

   // R2: the head is never consumed from an empty ring
   a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> (cnt != '0));

endmodule

// File: rtl/cos_head_ctl.sv
module cos_head_ctl
   import cos_pkg::*;
(
   input  logic head_vld,
   input  logic head_cond,
   input  logic head_kill,
   input  logic exec_ready,
   output logic rd_en,
   output logic dec_fire,
   output logic drop_fire
);
   head_state_e st;

   always_comb begin
      if (!head_vld)      st = HD_EMPTY;
      else if (head_kill) st = HD_KILL;
      else if (head_cond) st = HD_WAIT;
      else                st = HD_LIVE;
   end

   always_comb begin
      dec_fire  = 1'b0;
      drop_fire = 1'b0;
      unique case (st)
         HD_KILL: drop_fire = 1'b1;
         HD_LIVE: dec_fire  = exec_ready;
         default: ;
      endcase
      rd_en = dec_fire | drop_fire;
   end

endmodule

// File: rtl/cos_free_pipe.sv
module cos_free_pipe
   import cos_pkg::*;
#(
   parameter int LONG_DLY = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       dec_fire,
   input  logic [1:0] dec_lat,
   input  logic       drop_fire,
   output logic [1:0] free_cnt
);
   logic now_hit;
   assign now_hit = dec_fire && (free_delay(dec_lat, LONG_DLY) == 0);

   // stage d holds the positions due back d cycles from now
   for (genvar d = 1; d <= LONG_DLY; d++) begin : g_stage
      logic [1:0] due_r;
      logic       hit;
      assign hit = dec_fire && (free_delay(dec_lat, LONG_DLY) == d);
      if (d == LONG_DLY) begin : g_last
         always_ff @(posedge clk) begin
            if (!rst_n) due_r <= '0;
            else        due_r <= {1'b0, hit};
         end
      end else begin : g_mid
         always_ff @(posedge clk) begin
            if (!rst_n) due_r <= '0;
            else        due_r <= g_stage[d+1].due_r + {1'b0, hit};
         end
      end
   end

   assign free_cnt = g_stage[1].due_r + {1'b0, now_hit} + {1'b0, drop_fire};

   // R2: decode and discard never share a cycle
   a_r2_single_retire: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dec_fire, drop_fire}));

endmodule

// File: rtl/cond_op_stack.sv
module cond_op_stack
   import cos_pkg::*;
#(
   parameter int DEPTH    = 8,
   parameter int OPW      = 8,
   parameter int LONG_DLY = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           push_valid,
   input  logic [OPW-1:0] push_op,
   input  logic           push_cond,
   input  logic [1:0]     push_lat,
   output logic           full,
   input  logic           br_activate,
   input  logic           br_cancel,
   input  logic           exec_ready,
   output logic           dec_valid,
   output logic           drop,
   output logic [OPW-1:0] out_op,
   output logic [1:0]     out_lat,
   output logic [1:0]     free_cnt
);
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("cond_op_stack: DEPTH must be at least 2");
   end
   if (OPW < 1) begin : g_bad_opw
      $error("cond_op_stack: OPW must be at least 1");
   end
   if ((LONG_DLY < 1) || (LONG_DLY > MAX_FREE_DLY)) begin : g_bad_dly
      $error("cond_op_stack: LONG_DLY out of range");
   end

   logic          act_q, can_q;
   logic [CW-1:0] occ;
   logic          push_acc;
   logic          rd_en;
   logic          head_vld, head_cond, head_kill;
   logic [CW-1:0] ring_cnt;

   // resolution strobes spend one cycle in transit
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         can_q <= 1'b0;
      end else begin
         act_q <= br_activate;
         can_q <= br_cancel;
      end
   end

   assign full     = (occ == CW'(DEPTH));
   assign push_acc = push_valid && !full;

   always_ff @(posedge clk) begin
      if (!rst_n) occ <= '0;
      else        occ <= occ + CW'(push_acc) - CW'(free_cnt);
   end

   cos_ring #(.DEPTH(DEPTH), .OPW(OPW)) u_ring (
      .clk(clk), .rst_n(rst_n),
      .wr_en(push_acc), .wr_op(push_op), .wr_cond(push_cond), .wr_lat(push_lat),
      .rd_en(rd_en), .act_q(act_q), .can_q(can_q),
      .head_vld(head_vld), .head_op(out_op), .head_lat(out_lat),
      .head_cond(head_cond), .head_kill(head_kill), .count(ring_cnt)
   );

   cos_head_ctl u_head (
      .head_vld(head_vld), .head_cond(head_cond), .head_kill(head_kill),
      .exec_ready(exec_ready), .rd_en(rd_en),
      .dec_fire(dec_valid), .drop_fire(drop)
   );

   cos_free_pipe #(.LONG_DLY(LONG_DLY)) u_free (
      .clk(clk), .rst_n(rst_n),
      .dec_fire(dec_valid), .dec_lat(out_lat), .drop_fire(drop),
      .free_cnt(free_cnt)
   );

   // R4: input rule - one resolution at a time
   a_r4_one_resolution: assert property (@(posedge clk) disable iff (!rst_n)
      !(br_activate && br_cancel));

   // R4: a conditional head is never decoded
   a_r4_cond_head_waits: assert property (@(posedge clk) disable iff (!rst_n)
      (head_vld && head_cond) |-> !dec_valid);

   // R8: a push against a full stack leaves the store unchanged or smaller
   a_r8_full_ignores_push: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push_valid) |=> (ring_cnt <= $past(ring_cnt)));

   // R8: occupancy always covers every stored entry
   a_r8_occ_covers_ring: assert property (@(posedge clk) disable iff (!rst_n)
      ring_cnt <= occ);

   // R9: never more positions returned than are held
   a_r9_free_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      CW'(free_cnt) <= occ);

endmodule

// File: tb/cond_op_stack_test.sv
module cond_op_stack_test;
   localparam int DEPTH = 8;
   localparam int OPW   = 8;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic           rst_n = 1'b0;
   logic           push_valid = 1'b0;
   logic [OPW-1:0] push_op = '0;
   logic           push_cond = 1'b0;
   logic [1:0]     push_lat = '0;
   logic           full;
   logic           br_activate = 1'b0;
   logic           br_cancel = 1'b0;
   logic           exec_ready = 1'b0;
   logic           dec_valid, drop;
   logic [OPW-1:0] out_op;
   logic [1:0]     out_lat;
   logic [1:0]     free_cnt;

   cond_op_stack #(.DEPTH(DEPTH), .OPW(OPW), .LONG_DLY(2)) uut (
      .clk(clk), .rst_n(rst_n),
      .push_valid(push_valid), .push_op(push_op), .push_cond(push_cond), .push_lat(push_lat),
      .full(full), .br_activate(br_activate), .br_cancel(br_cancel),
      .exec_ready(exec_ready), .dec_valid(dec_valid), .drop(drop),
      .out_op(out_op), .out_lat(out_lat), .free_cnt(free_cnt)
   );

   typedef struct {
      logic [OPW-1:0] op;
      logic [1:0]     lat;
      bit             cond;
      bit             kill;
   } item_t;

   item_t exp_q[$];
   int checks = 0;
   int errors = 0;
   int n_dec = 0;
   int n_drop = 0;
   bit mon_en = 1'b0;
   int due_now = 0, due_next = 0, occ_m = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && mon_en) begin
         int fexp;
         check(!(dec_valid && drop), "R2", "decode and drop together", 1, 0);
         if (dec_valid || drop) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R2", "retire from empty model, op", int'(out_op), -1);
            end else begin
               item_t it;
               it = exp_q.pop_front();
               check(out_op == it.op, "R2", "retire order op", int'(out_op), int'(it.op));
               check(out_lat == it.lat, "R7", "retired latency class", int'(out_lat), int'(it.lat));
               check(drop == it.kill, "R5", "drop versus decode", int'(drop), int'(it.kill));
               if (dec_valid)
                  check(!it.cond, "R4", "unresolved entry decoded", 1, 0);
            end
            if (dec_valid) n_dec++;
            if (drop) n_drop++;
         end
         fexp = due_now + int'(drop) + int'(dec_valid && out_lat == 2'd0);
         check(int'(free_cnt) == fexp, "R9", "free_cnt per cycle", int'(free_cnt), fexp);
         check(full == (occ_m == DEPTH), "R8", "full flag", int'(full), int'(occ_m == DEPTH));
         due_now  = due_next + int'(dec_valid && out_lat == 2'd1);
         due_next = int'(dec_valid && out_lat >= 2'd2);
         occ_m    = occ_m + int'(push_valid && !full) - fexp;
      end
   end

   task automatic drive_idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(posedge clk); #1;
         push_valid = 1'b0; br_activate = 1'b0; br_cancel = 1'b0;
      end
   endtask

   task automatic push(input logic [OPW-1:0] op, input bit cond, input logic [1:0] lat);
      @(posedge clk); #1;
      br_activate = 1'b0; br_cancel = 1'b0;
      push_valid = 1'b1; push_op = op; push_cond = cond; push_lat = lat;
      if (!full) exp_q.push_back('{op: op, lat: lat, cond: cond, kill: 1'b0});
   endtask

   task automatic resolve(input bit cancel);
      @(posedge clk); #1;
      push_valid = 1'b0;
      br_activate = !cancel; br_cancel = cancel;
      for (int i = 0; i < exp_q.size(); i++) begin
         if (exp_q[i].cond) begin
            exp_q[i].cond = 1'b0;
            exp_q[i].kill = cancel;
         end
      end
   endtask

   // conditional push in the cycle the resolution lands (R6)
   task automatic push_landing(input logic [OPW-1:0] op, input logic [1:0] lat, input bit cancel);
      @(posedge clk); #1;
      br_activate = 1'b0; br_cancel = 1'b0;
      push_valid = 1'b1; push_op = op; push_cond = 1'b1; push_lat = lat;
      if (!full) exp_q.push_back('{op: op, lat: lat, cond: 1'b0, kill: cancel});
   endtask

   initial begin
      int d0, p0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(!full, "R1", "full after reset", int'(full), 0);
      check(!dec_valid && !drop, "R1", "retire strobes after reset", int'(dec_valid | drop), 0);
      check(free_cnt == 2'd0, "R1", "free_cnt after reset", int'(free_cnt), 0);
      mon_en = 1'b1;

      // R3 stall on exec_ready, then decode; R7 one-cycle free in decode cycle
      exec_ready = 1'b0;
      push(8'h11, 1'b0, 2'd0);
      drive_idle(1);
      @(negedge clk);
      check(!dec_valid, "R3", "decode while exec_ready low", int'(dec_valid), 0);
      drive_idle(1);
      @(negedge clk);
      check(!dec_valid, "R3", "still stalled", int'(dec_valid), 0);
      @(posedge clk); #1 exec_ready = 1'b1;
      @(negedge clk);
      check(dec_valid && out_op == 8'h11, "R3", "decode when ready, op", int'(out_op), 'h11);
      check(free_cnt == 2'd1, "R7", "class 0 frees in decode cycle", int'(free_cnt), 1);
      drive_idle(2);

      // R4 activation timing
      push(8'h22, 1'b1, 2'd0);
      drive_idle(1);
      @(negedge clk);
      check(!dec_valid, "R4", "conditional head held", int'(dec_valid), 0);
      resolve(1'b0);
      @(negedge clk);
      check(!dec_valid, "R4", "strobe cycle", int'(dec_valid), 0);
      drive_idle(1);
      @(negedge clk);
      check(!dec_valid, "R4", "transit cycle", int'(dec_valid), 0);
      drive_idle(1);
      @(negedge clk);
      check(dec_valid && out_op == 8'h22, "R4", "decode two cycles after strobe, op", int'(out_op), 'h22);
      drive_idle(2);

      // R5 and R6 cancel with live entries around condemned ones
      d0 = n_drop; p0 = n_dec;
      exec_ready = 1'b0;
      push(8'h31, 1'b0, 2'd1);
      push(8'h32, 1'b1, 2'd0);
      push(8'h33, 1'b1, 2'd2);
      resolve(1'b1);
      push_landing(8'h34, 2'd1, 1'b1);
      push(8'h35, 1'b0, 2'd0);
      drive_idle(2);
      exec_ready = 1'b1;
      drive_idle(10);
      check(n_drop - d0 == 3, "R5", "condemned entries dropped", n_drop - d0, 3);
      check(n_dec - p0 == 2, "R6", "live entries decoded past cancel", n_dec - p0, 2);

      // R6 activation covers stored and landing-cycle entries
      d0 = n_drop; p0 = n_dec;
      exec_ready = 1'b0;
      push(8'h41, 1'b1, 2'd0);
      push(8'h42, 1'b1, 2'd3);
      resolve(1'b0);
      push_landing(8'h43, 2'd0, 1'b0);
      drive_idle(2);
      exec_ready = 1'b1;
      drive_idle(8);
      check(n_dec - p0 == 3, "R6", "activated entries decoded", n_dec - p0, 3);
      check(n_drop == d0, "R6", "no drop after activate", n_drop - d0, 0);

      // R8 fill, ignored push, drain
      exec_ready = 1'b0;
      for (int i = 0; i < DEPTH; i++) push(8'h50 + 8'(i), 1'b0, 2'(i % 3));
      drive_idle(1);
      @(negedge clk);
      check(full, "R8", "full at DEPTH entries", int'(full), 1);
      push(8'hEE, 1'b0, 2'd0);
      drive_idle(1);
      exec_ready = 1'b1;
      drive_idle(DEPTH + 5);
      @(negedge clk);
      check(!full, "R8", "full released after drain", int'(full), 0);
      check(exp_q.size() == 0, "R8", "entries left in model", exp_q.size(), 0);

      // R9 three coincident returns
      exec_ready = 1'b0;
      push(8'h61, 1'b0, 2'd2);
      push(8'h62, 1'b0, 2'd1);
      push(8'h63, 1'b0, 2'd0);
      drive_idle(1);
      @(posedge clk); #1 exec_ready = 1'b1;
      @(negedge clk);
      @(negedge clk);
      @(negedge clk);
      check(free_cnt == 2'd3, "R9", "coincident returns", int'(free_cnt), 3);
      drive_idle(3);

      // R2 mixed stream
      for (int i = 0; i < 60; i++) begin
         if (i % 11 == 10) begin
            resolve((i % 22) == 10);
            drive_idle(1);
         end else begin
            push(8'h80 + 8'(i), (i % 4) >= 2, 2'(i % 4));
         end
         exec_ready = (i % 3) != 0;
      end
      resolve(1'b0);
      drive_idle(1);
      exec_ready = 1'b1;
      drive_idle(2 * DEPTH + 6);
      @(negedge clk);
      check(exp_q.size() == 0, "R2", "stream fully retired", exp_q.size(), 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R2 watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule